// File: doc/BRIEF.md
# Channel Status Double Buffer

This block gathers the channel status bits recovered by a serial digital audio receiver (IEC 60958 style). For every subframe the front end hands over one status bit together with the subframe identity (A or B). A block-start strobe marks the first frame of each 192-frame block. The bits of both channels are assembled in a working store. Once a complete block of both channels has arrived, the whole store is copied in one step into a holding store that the host reads.

The host sees the holding store as a 24-byte window of byte-wide registers. A control register chooses whether the window shows channel A or channel B, and also sets how the interrupt behaves. A sticky interrupt flag reports fresh status data. It can fire on every completed block, or only when the leading five status bytes of either channel differ from the block held before. The window changes only on whole-block boundaries, so the host never reads a mix of two blocks.

Top module: `cs_dual_capture`

## Requirements
- R1: After reset, `irq` and `pro_fmt` are 0, the control register reads 0, and every window byte reads 0.
- R2: A bit is captured only while a block is open. A block opens when `bit_valid`, `blk_start` and subframe A (`bit_is_b`=0) are all high together. Bits arriving with no open block change nothing the host can see and raise no interrupt.
- R3: Within each channel, status bit n is held in window byte n/8 at bit position n mod 8 (least significant first). Byte k reads at address 0x20+k, for k = 0..23.
- R4: In a block, each A bit is stored at the current frame index, and each B bit is stored at that index and then advances it. The holding store changes only at the clock edge one cycle after the B bit of frame 191 is accepted. At that edge it takes both complete channels.
- R5: A new block start before frame 191 completes discards the partial block. No copy and no interrupt come from it, and capture restarts at frame 0.
- R6: Control register bit 0 at address 0x10 selects the window channel: 0 gives A, 1 gives B. The full control byte reads back at 0x10.
- R7: With control bit 1 clear, `irq` is set at every copy into the holding store.
- R8: With control bit 1 set, a copy sets `irq` only if status bits 0..39 of channel A or of channel B differ from the held values being replaced.
- R9: `irq` stays set until a write to address 0x11 with data bit 0 = 1. If a clear and a set fall in the same cycle, `irq` ends up set. Address 0x11 reads `irq` in bit 0.
- R10: Reads at addresses other than 0x10, 0x11 and 0x20..0x37 return 0.
- R11: `pro_fmt` equals bit 0 of byte 0 of the selected channel in the holding store. This bit is the professional/consumer format flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A status bit is presented this cycle |
| bit_val | input | 1 | Status bit value |
| bit_is_b | input | 1 | 1 when the bit belongs to subframe B |
| blk_start | input | 1 | Marks the first frame of a block (with an A bit) |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| irq | output | 1 | Sticky fresh-status interrupt flag |
| pro_fmt | output | 1 | Format flag of the selected held channel |

## Verification
The assertions watch, on every cycle, the properties that need no history beyond one clock. They check that the frame index stays in range, that the holding store stays put except at a copy edge, and that a restart is never followed by a copy. They also check that the interrupt is sticky, that it clears only on request, and that it always sets at a copy in every-block mode. Bit placement, the channel select, the discarding of a partial block and stray bits, and the leading-byte change test all depend on whole blocks of stimulus. Only the bench's scenarios show these, by comparing every host read against a model on each clock.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef logic [7:0] cs_addr_t;

  // control register layout
  typedef struct packed {
    logic [5:0] spare;
    logic       irq_on_change;
    logic       sel_b;
  } cs_ctrl_t;

  // offset of an address from the base of the byte window
  function automatic cs_addr_t cs_win_offset(input cs_addr_t addr, input cs_addr_t base);
    return addr - base;
  endfunction

  // true when addr falls inside a window of nbytes starting at base
  function automatic logic cs_in_window(input cs_addr_t addr, input cs_addr_t base,
                                        input int unsigned nbytes);
    return (addr >= base) && (int'(cs_win_offset(addr, base)) < int'(nbytes));
  endfunction

endpackage

// File: rtl/cs_frame_tracker.sv
module cs_frame_tracker #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_is_b,
  input  logic             blk_start,
  output logic             wr_a,
  output logic             wr_b,
  output logic [IDX_W-1:0] wr_idx,
  output logic             restart,
  output logic             blk_done
);

  logic             open_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_b;

  assign restart = bit_valid & blk_start & ~bit_is_b;
  assign wr_a    = bit_valid & ~bit_is_b & (restart | open_q);
  assign wr_b    = bit_valid & bit_is_b & open_q;
  assign wr_idx  = restart ? '0 : idx_q;
  assign last_b  = wr_b & (idx_q == IDX_W'(FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      idx_q    <= '0;
      blk_done <= 1'b0;
    end else begin
      blk_done <= last_b;
      if (restart) begin
        open_q <= 1'b1;
        idx_q  <= '0;
      end else if (wr_b) begin
        if (last_b) begin
          open_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < FRAMES) else $error("frame index out of range");

  assert_restart_no_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !blk_done) else $error("copy after restart");

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done) else $error("copy strobe longer than one cycle");

endmodule

// File: rtl/cs_status_store.sv
module cs_status_store #(
  parameter int FRAMES    = 192,
  parameter int LEAD_BITS = 40,
  localparam int IDX_W    = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              bit_val,
  input  logic              xfer,
  output logic [FRAMES-1:0] hold_a,
  output logic [FRAMES-1:0] hold_b,
  output logic              lead_changed
);

  logic [FRAMES-1:0] work [2];
  logic [FRAMES-1:0] hold [2];
  logic [1:0]        wr_ch;
  logic [1:0]        ch_diff;

  assign wr_ch = {wr_b, wr_a};

  function automatic logic lead_differs(input logic [FRAMES-1:0] fresh,
                                        input logic [FRAMES-1:0] old);
    return fresh[LEAD_BITS-1:0] != old[LEAD_BITS-1:0];
  endfunction

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work[ch] <= '0;
        hold[ch] <= '0;
      end else begin
        if (xfer) hold[ch] <= work[ch];
        if (wr_ch[ch]) work[ch][wr_idx] <= bit_val;
      end
    end
    assign ch_diff[ch] = lead_differs(work[ch], hold[ch]);
  end

  assign hold_a       = hold[0];
  assign hold_b       = hold[1];
  assign lead_changed = |ch_diff;

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(hold_a) && $stable(hold_b))) else $error("holding store moved without a copy");

endmodule

// File: rtl/cs_host_port.sv
module cs_host_port
  import cs_pkg::*;
#(
  parameter int       FRAMES    = 192,
  parameter cs_addr_t WIN_BASE  = 8'h20,
  parameter cs_addr_t CTRL_ADDR = 8'h10,
  parameter cs_addr_t IRQ_ADDR  = 8'h11,
  localparam int      NBYTES    = FRAMES / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cs_addr_t          wr_addr,
  input  logic [7:0]        wr_data,
  input  cs_addr_t          rd_addr,
  input  logic [FRAMES-1:0] hold_a,
  input  logic [FRAMES-1:0] hold_b,
  input  logic              xfer,
  input  logic              lead_changed,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic              pro_fmt
);

  cs_ctrl_t          ctrl_q;
  logic              irq_set;
  logic              irq_clr;
  logic [FRAMES-1:0] sel_vec;
  cs_addr_t          off;
  logic [7:0]        win_byte;

  assign irq_set = xfer & (~ctrl_q.irq_on_change | lead_changed);
  assign irq_clr = wr_en & (wr_addr == IRQ_ADDR) & wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= irq_set | (irq & ~irq_clr);
      if (wr_en && wr_addr == CTRL_ADDR) ctrl_q <= cs_ctrl_t'(wr_data);
    end
  end

  assign sel_vec = ctrl_q.sel_b ? hold_b : hold_a;
  assign off     = cs_win_offset(rd_addr, WIN_BASE);
  assign pro_fmt = sel_vec[0];

  always_comb begin
    win_byte = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (off == cs_addr_t'(k)) win_byte = sel_vec[8*k +: 8];
    end
  end

  always_comb begin
    if (rd_addr == CTRL_ADDR)                       rd_data = ctrl_q;
    else if (rd_addr == IRQ_ADDR)                   rd_data = {7'b0, irq};
    else if (cs_in_window(rd_addr, WIN_BASE, NBYTES)) rd_data = win_byte;
    else                                            rd_data = '0;
  end

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq) else $error("interrupt dropped without clear");

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !xfer) |=> !irq) else $error("interrupt clear ignored");

  assert_every_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ctrl_q.irq_on_change) |=> irq) else $error("copy without interrupt");

  assert_change_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ctrl_q.irq_on_change && !lead_changed && !irq) |=> !irq)
    else $error("interrupt without leading change");

endmodule

// File: rtl/cs_dual_capture.sv
module cs_dual_capture
  import cs_pkg::*;
#(
  parameter int       FRAMES     = 192,
  parameter int       LEAD_BYTES = 5,
  parameter cs_addr_t WIN_BASE   = 8'h20,
  parameter cs_addr_t CTRL_ADDR  = 8'h10,
  parameter cs_addr_t IRQ_ADDR   = 8'h11,
  localparam int      IDX_W      = $clog2(FRAMES),
  localparam int      LEAD_BITS  = LEAD_BYTES * 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_val,
  input  logic       bit_is_b,
  input  logic       blk_start,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       pro_fmt
);

  logic              wr_a;
  logic              wr_b;
  logic [IDX_W-1:0]  wr_idx;
  logic              restart;
  logic              blk_done;
  logic [FRAMES-1:0] hold_a;
  logic [FRAMES-1:0] hold_b;
  logic              lead_changed;

  cs_frame_tracker #(.FRAMES(FRAMES)) u_track (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_is_b(bit_is_b),
    .blk_start(blk_start), .wr_a(wr_a), .wr_b(wr_b), .wr_idx(wr_idx),
    .restart(restart), .blk_done(blk_done)
  );

  cs_status_store #(.FRAMES(FRAMES), .LEAD_BITS(LEAD_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wr_idx(wr_idx),
    .bit_val(bit_val), .xfer(blk_done), .hold_a(hold_a), .hold_b(hold_b),
    .lead_changed(lead_changed)
  );

  cs_host_port #(.FRAMES(FRAMES), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR),
                 .IRQ_ADDR(IRQ_ADDR)) u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .hold_a(hold_a), .hold_b(hold_b), .xfer(blk_done),
    .lead_changed(lead_changed), .rd_data(rd_data), .irq(irq), .pro_fmt(pro_fmt)
  );

  assert_restart_keeps_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ($stable(hold_a) && $stable(hold_b))) else $error("restart moved holding store");

endmodule

// File: tb/cs_dual_capture_bench.sv
module cs_dual_capture_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0, bit_val = 1'b0, bit_is_b = 1'b0, blk_start = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq, pro_fmt;

  always #4 clk = ~clk;  // 125 MHz

  cs_dual_capture u_cs_dual_capture (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
    .bit_is_b(bit_is_b), .blk_start(blk_start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .pro_fmt(pro_fmt)
  );

  int    n_chk = 0, n_bad = 0;
  bit    chk_on = 0, finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit       mw [2][192];
  bit       mh [2][192];
  int       m_idx;
  bit       m_open, m_pend, m_irq;
  bit [7:0] m_ctrl;

  always @(posedge clk) begin : model
    bit set, clr, diff;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) for (int i = 0; i < 192; i++) begin mw[c][i] = 0; mh[c][i] = 0; end
      m_idx = 0; m_open = 0; m_pend = 0; m_irq = 0; m_ctrl = 0;
    end else begin
      set = 0; diff = 0;
      if (m_pend) begin
        for (int c = 0; c < 2; c++) for (int i = 0; i < 40; i++) if (mw[c][i] != mh[c][i]) diff = 1;
        set = !m_ctrl[1] || diff;
        for (int c = 0; c < 2; c++) for (int i = 0; i < 192; i++) mh[c][i] = mw[c][i];
      end
      clr = wr_en && wr_addr == 8'h11 && wr_data[0];
      m_irq = set ? 1'b1 : (clr ? 1'b0 : m_irq);
      if (wr_en && wr_addr == 8'h10) m_ctrl = wr_data;
      m_pend = 0;
      if (bit_valid) begin
        if (!bit_is_b && blk_start) begin
          m_idx = 0; m_open = 1; mw[0][0] = bit_val;
        end else if (m_open) begin
          if (!bit_is_b) mw[0][m_idx] = bit_val;
          else begin
            mw[1][m_idx] = bit_val;
            if (m_idx == 191) begin m_open = 0; m_pend = 1; m_idx = 0; end
            else m_idx++;
          end
        end
      end
    end
  end

  function automatic [7:0] exp_rd(input [7:0] a);
    bit [7:0] b;
    b = 0;
    if (a == 8'h10) return m_ctrl;
    if (a == 8'h11) return {7'b0, m_irq};
    if (a >= 8'h20 && a <= 8'h37)
      for (int k = 0; k < 8; k++) b[k] = mh[m_ctrl[0]][(a - 8'h20) * 8 + k];
    return b;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge; sweep the read address
  always @(negedge clk) begin
    if (!chk_on) rd_addr <= 8'h0C;
    else begin
      string rq;
      if (rd_addr >= 8'h20 && rd_addr <= 8'h37) rq = cur_req;
      else if (rd_addr == 8'h10 || rd_addr == 8'h11) rq = "R9";
      else rq = "R10";
      check(rq, "rd_data", rd_data, exp_rd(rd_addr));
      check(cur_req, "irq", irq, m_irq);
      check("R11", "pro_fmt", pro_fmt, mh[m_ctrl[0]][0]);
      rd_addr <= (rd_addr >= 8'h3D) ? 8'h0C : rd_addr + 8'h01;
    end
  end

  function automatic bit pat(input int seed, input int ch, input int n);
    if (n == 0) return bit'(seed[0] ^ ch[0]);
    return ((n * 5 + seed * 3 + ch * 7) % 9) < 4;
  endfunction

  task automatic send_bit(input bit isb, input bit v, input bit st, input bit clr_gap);
    bit_valid = 1; bit_is_b = isb; bit_val = v; blk_start = st;
    @(negedge clk);
    bit_valid = 0; blk_start = 0;
    if (clr_gap) begin wr_en = 1; wr_addr = 8'h11; wr_data = 8'h01; end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send_block(input int seed, input bit st, input int frames,
                            input int fa, input int fb, input bit clr_end);
    for (int f = 0; f < frames; f++) begin
      send_bit(0, pat(seed, 0, f) ^ (f == fa), st && f == 0, 0);
      send_bit(1, pat(seed, 1, f) ^ (f == fb), 0, clr_end && f == frames - 1);
    end
  endtask

  task automatic host_write(input [7:0] a, input [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; chk_on = 1;
    cur_req = "R1";
    check("R1", "irq after reset", irq, 0);
    check("R1", "pro_fmt after reset", pro_fmt, 0);
    idle(60);
    // R2: a full block's worth of bits with no start strobe
    cur_req = "R2";
    send_block(1, 0, 192, -1, -1, 0);
    idle(4);
    check("R2", "irq without block start", irq, 0);
    // R4/R7: complete block, every-block interrupt mode
    cur_req = "R4";
    send_block(2, 1, 192, -1, -1, 0);
    idle(3);
    check("R7", "irq after block", irq, 1);
    cur_req = "R3";
    idle(60);
    // R6: channel B view
    cur_req = "R6";
    host_write(8'h10, 8'h01);
    idle(60);
    host_write(8'h11, 8'h01);
    idle(2);
    check("R9", "irq cleared", irq, 0);
    // R5: partial block then restart; clear coincides with the copy
    cur_req = "R5";
    send_block(3, 1, 100, -1, -1, 0);
    idle(3);
    check("R5", "irq after partial", irq, 0);
    send_block(4, 1, 192, -1, -1, 1);
    idle(2);
    check("R9", "set wins over clear", irq, 1);
    idle(60);
    // R8: change-gated interrupt mode, channel A selected
    cur_req = "R8";
    host_write(8'h10, 8'h02);
    host_write(8'h11, 8'h01);
    send_block(4, 1, 192, -1, -1, 0);
    idle(3);
    check("R8", "same block no irq", irq, 0);
    send_block(4, 1, 192, 20, -1, 0);
    idle(3);
    check("R8", "byte 2 change irq", irq, 1);
    host_write(8'h11, 8'h01);
    send_block(4, 1, 192, 20, 100, 0);
    idle(3);
    check("R8", "deep B change no irq", irq, 0);
    send_block(4, 1, 192, 20, 33, 0);
    idle(3);
    check("R8", "lead B change irq", irq, 1);
    host_write(8'h10, 8'h03);
    cur_req = "R11";
    idle(60);
    summary();
  end

endmodule